// File: doc/BRIEF.md
# Mailbox Memory-Load Register Interface

This block sits on the device side of a 16-bit management register port. Through it a host moves 32-bit words into an internal memory. The host first loads a word address as two 16-bit halves and a data word as two 16-bit halves. It then writes a command that commits the word. After each commit the address advances by one word, so a long image can be streamed with only the data halves and the command repeated.

While words are committed the block keeps a running CRC-16 over them, and the host can read it back to confirm what reached memory. The CRC uses polynomial 0x1021 and shifts in the most significant bit first. For each word it consumes the high byte first and the low byte last. A command bit clears the CRC before a new load.

The memory side is a write-only port that carries a word-aligned byte address and 32 data bits. For `WR_LAT` cycles after each commit the block reports busy, and it drops any execute command that arrives in that window.

Top module: `mbx_load_regs`

## Requirements
- R1: After reset the address, data and CRC registers read 0x0000, the busy flag (bit 8 of index 0x200) reads 0 and `mem_we` is low.
- R2: Writing index 0x202 sets byte address bits 31:16. Writing index 0x203 sets byte address bits 15:2, and its bits 1:0 are ignored. Index 0x203 reads back with bits 1:0 equal to 0.
- R3: Index 0x204 holds data bits 31:16 and index 0x205 holds data bits 15:0. Both read back what was written.
- R4: A write to index 0x200 with bit 15 (execute) and bit 14 (write) both set, made while not busy, gives a one-cycle `mem_we` pulse in the next cycle. In that cycle `mem_addr` is the current byte address with bits 1:0 equal to 0, and `mem_wdata` is {data high, data low}.
- R5: A write to index 0x200 that sets only one of bits 15 and 14 commits nothing.
- R6: Each commit advances the byte address by 4, and the new value can be read at indices 0x202/0x203. Writing either address index overrides the advanced value.
- R7: Each commit advances the CRC (polynomial 0x1021, MSB first) over bytes 31:24, 23:16, 15:8 and 7:0, in that order. Index 0x201 returns the CRC.
- R8: Bit 12 of a write to index 0x200 clears the CRC to 0x0000. If the same write also commits, the word's bytes are applied to the cleared value.
- R9: After a commit, busy reads 1 for exactly `WR_LAT` cycles. An execute-write that arrives while busy leaves memory, address and CRC unchanged.
- R10: Writes to index 0x201 have no effect. Unmapped indices read 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | IDX_W | Register index for both reads and writes |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for `reg_idx` (combinational) |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |

## Verification
The hardest case to reach is a command that arrives inside the busy window. It needs two execute-writes closer together than `WR_LAT` cycles, and the second must then be shown to leave no trace in memory, address or CRC. The bench issues back-to-back command writes in consecutive cycles and then reads the address and CRC. It also combines a CRC clear with a commit in one write, to check that the clear is applied before the word. A behavioural reference model is compared with every output on every clock.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int DATA_W  = 16;
    localparam int WORD_W  = 32;
    localparam int WADDR_W = 30;
    localparam int CRC_W   = 16;

    localparam logic [15:0] IDX_CMD    = 16'h0200;
    localparam logic [15:0] IDX_CRC    = 16'h0201;
    localparam logic [15:0] IDX_ADDR_H = 16'h0202;
    localparam logic [15:0] IDX_ADDR_L = 16'h0203;
    localparam logic [15:0] IDX_DATA_H = 16'h0204;
    localparam logic [15:0] IDX_DATA_L = 16'h0205;

    localparam int BIT_EXEC  = 15;
    localparam int BIT_WRITE = 14;
    localparam int BIT_CLR   = 12;
    localparam int BIT_BUSY  = 8;

    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

    typedef struct packed {
        logic [WADDR_W-1:0] addr;
        logic [WORD_W-1:0]  data;
        logic [CRC_W-1:0]   crc;
        logic               we;
        logic [WADDR_W-1:0] out_addr;
        logic [WORD_W-1:0]  out_data;
    } mbx_state_t;
endpackage

// File: rtl/mbx_crc_step.sv
module mbx_crc_step
    import mbx_pkg::*;
#(
    parameter int IN_W = WORD_W
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic [IN_W-1:0]  word_in,
    output logic [CRC_W-1:0] crc_out
);
    logic [CRC_W-1:0] chain [0:IN_W];

    assign chain[0] = crc_in;

    for (genvar i = 0; i < IN_W; i++) begin : g_bit
        logic fb;
        assign fb = chain[i][CRC_W-1] ^ word_in[IN_W-1-i];
        assign chain[i+1] = {chain[i][CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end

    assign crc_out = chain[IN_W];
endmodule

// File: rtl/mbx_busy_ctr.sv
module mbx_busy_ctr #(
    parameter int WR_LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(WR_LAT + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CNT_W'(WR_LAT);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/mbx_load_regs.sv
module mbx_load_regs
    import mbx_pkg::*;
#(
    parameter int IDX_W  = 16,
    parameter int WR_LAT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata
);
    localparam int HALF = WORD_W / 2;
    localparam int LO_W = WADDR_W - HALF;

    mbx_state_t       s_d, s_q;
    logic             busy;
    logic             commit;
    logic             is_cmd;
    logic [CRC_W-1:0] crc_base;
    logic [CRC_W-1:0] crc_next;

    assign is_cmd = reg_wr && (reg_idx == IDX_W'(IDX_CMD));
    assign commit = is_cmd && reg_wdata[BIT_EXEC] && reg_wdata[BIT_WRITE] && !busy;
    assign crc_base = (is_cmd && reg_wdata[BIT_CLR]) ? '0 : s_q.crc;

    mbx_crc_step #(.IN_W(WORD_W)) u_crc (
        .crc_in  (crc_base),
        .word_in (s_q.data),
        .crc_out (crc_next)
    );

    mbx_busy_ctr #(.WR_LAT(WR_LAT)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .start (commit),
        .busy  (busy)
    );

    always_comb begin
        s_d    = s_q;
        s_d.we = 1'b0;
        if (reg_wr) begin
            if (reg_idx == IDX_W'(IDX_ADDR_H)) s_d.addr[WADDR_W-1:LO_W] = reg_wdata;
            if (reg_idx == IDX_W'(IDX_ADDR_L)) s_d.addr[LO_W-1:0] = reg_wdata[15:2];
            if (reg_idx == IDX_W'(IDX_DATA_H)) s_d.data[WORD_W-1:HALF] = reg_wdata;
            if (reg_idx == IDX_W'(IDX_DATA_L)) s_d.data[HALF-1:0] = reg_wdata;
        end
        if (is_cmd) begin
            s_d.crc = crc_base;
        end
        if (commit) begin
            s_d.we       = 1'b1;
            s_d.out_addr = s_q.addr;
            s_d.out_data = s_q.data;
            s_d.crc      = crc_next;
            s_d.addr     = s_q.addr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_idx == IDX_W'(IDX_CMD))    reg_rdata[BIT_BUSY] = busy;
        if (reg_idx == IDX_W'(IDX_CRC))    reg_rdata = s_q.crc;
        if (reg_idx == IDX_W'(IDX_ADDR_H)) reg_rdata = s_q.addr[WADDR_W-1:LO_W];
        if (reg_idx == IDX_W'(IDX_ADDR_L)) reg_rdata = {s_q.addr[LO_W-1:0], 2'b00};
        if (reg_idx == IDX_W'(IDX_DATA_H)) reg_rdata = s_q.data[WORD_W-1:HALF];
        if (reg_idx == IDX_W'(IDX_DATA_L)) reg_rdata = s_q.data[HALF-1:0];
    end

    assign mem_we    = s_q.we;
    assign mem_addr  = {s_q.out_addr, 2'b00};
    assign mem_wdata = s_q.out_data;
endmodule

// File: rtl/mbx_load_regs_chk.sv
module mbx_load_regs_chk
    import mbx_pkg::*;
#(
    parameter int IDX_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [IDX_W-1:0]   reg_idx,
    input logic [15:0]        reg_wdata,
    input logic               mem_we,
    input logic [31:0]        mem_addr,
    input logic               busy,
    input logic [WADDR_W-1:0] addr_word,
    input logic [CRC_W-1:0]   crc_val,
    input logic [WORD_W-1:0]  data_word
);
    logic cmd_wr, exec_wr;
    assign cmd_wr  = reg_wr && (reg_idx == IDX_W'(IDX_CMD));
    assign exec_wr = cmd_wr && reg_wdata[BIT_EXEC] && reg_wdata[BIT_WRITE];

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);                                                   // R4
    AST_WE_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);                                                      // R9
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr[1:0] == 2'b00);                                    // R4
    AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> addr_word == mem_addr[31:2] + 1'b1);                        // R6
    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_wr && busy) |=> !mem_we);                                        // R9
    AST_CRC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && reg_wdata[BIT_CLR] && !exec_wr) |=> crc_val == '0);         // R8
    AST_HALF_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !(reg_wdata[BIT_EXEC] && reg_wdata[BIT_WRITE])) |=> !mem_we); // R5
    AST_DATA_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_idx == IDX_W'(IDX_DATA_H)) |=> data_word[31:16] == $past(reg_wdata)); // R3
endmodule

bind mbx_load_regs mbx_load_regs_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_idx   (reg_idx),
    .reg_wdata (reg_wdata),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .busy      (busy),
    .addr_word (s_q.addr),
    .crc_val   (s_q.crc),
    .data_word (s_q.data)
);

// File: tb/mbx_load_regs_tb.sv
module mbx_load_regs_tb;
    localparam int IDX_W  = 16;
    localparam int WR_LAT = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic [IDX_W-1:0] reg_idx = '0;
    logic [15:0]      reg_wdata = '0;
    logic [15:0]      reg_rdata;
    logic             mem_we;
    logic [31:0]      mem_addr;
    logic [31:0]      mem_wdata;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    mbx_load_regs #(.IDX_W(IDX_W), .WR_LAT(WR_LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    // behavioural reference model
    logic [31:0] m_baddr, m_data, m_oaddr, m_odata;
    logic [15:0] m_crc;
    logic        m_we;
    int          m_busy;

    function automatic logic [15:0] crc_word(input logic [15:0] c, input logic [31:0] w);
        logic [15:0] r = c;
        for (int b = 3; b >= 0; b--) begin
            logic [7:0] by = w[b*8 +: 8];
            for (int k = 7; k >= 0; k--) begin
                logic top = r[15] ^ by[k];
                r = {r[14:0], 1'b0};
                if (top) r = r ^ 16'h1021;
            end
        end
        return r;
    endfunction

    function automatic logic [15:0] model_read(input logic [15:0] idx);
        case (idx)
            16'h0200: return (m_busy != 0) ? 16'h0100 : 16'h0000;
            16'h0201: return m_crc;
            16'h0202: return m_baddr[31:16];
            16'h0203: return {m_baddr[15:2], 2'b00};
            16'h0204: return m_data[31:16];
            16'h0205: return m_data[15:0];
            default:  return 16'h0000;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_baddr = '0; m_data = '0; m_oaddr = '0; m_odata = '0;
            m_crc = '0; m_we = 1'b0; m_busy = 0;
        end else begin
            bit go;
            go = reg_wr && reg_idx == 16'h0200 && reg_wdata[15] && reg_wdata[14] && m_busy == 0;
            m_we = 1'b0;
            if (m_busy > 0) m_busy--;
            if (reg_wr) begin
                case (reg_idx)
                    16'h0202: m_baddr[31:16] = reg_wdata;
                    16'h0203: m_baddr[15:2] = reg_wdata[15:2];
                    16'h0204: m_data[31:16] = reg_wdata;
                    16'h0205: m_data[15:0] = reg_wdata;
                    16'h0200: if (reg_wdata[12]) m_crc = 16'h0000;
                    default: ;
                endcase
            end
            if (go) begin
                m_we = 1'b1; m_oaddr = m_baddr; m_odata = m_data;
                m_crc = crc_word(m_crc, m_data);
                m_baddr = m_baddr + 32'd4;
                m_busy = WR_LAT;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // per-clock comparison with the model
    always begin
        @(posedge clk);
        #2;
        if (rst_n && !done) begin
            chk("R4 mem_we", {31'd0, mem_we}, {31'd0, m_we});
            if (m_we) begin
                chk("R4 mem_addr", mem_addr, m_oaddr);
                chk("R4 mem_wdata", mem_wdata, m_odata);
            end
            chk("R9 busy", {31'd0, u_busy_bit()}, {31'd0, m_busy != 0});
            chk("R10 read path", {16'd0, reg_rdata}, {16'd0, model_read(reg_idx)});
        end
    end

    function automatic logic u_busy_bit();
        return (reg_idx == 16'h0200) ? reg_rdata[8] : (m_busy != 0);
    endfunction

    task automatic wr(input logic [15:0] idx, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] idx, input string req, input logic [15:0] exp);
        @(negedge clk);
        reg_wr = 1'b0; reg_idx = idx;
        #1;
        chk(req, {16'd0, reg_rdata}, {16'd0, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        rd(16'h0201, "R1 crc", 16'h0000);
        rd(16'h0202, "R1 addr hi", 16'h0000);
        rd(16'h0205, "R1 data lo", 16'h0000);
        rd(16'h0200, "R1 busy", 16'h0000);
        chk("R1 mem_we", {31'd0, mem_we}, 32'd0);
        // R2 address halves
        wr(16'h0202, 16'h3FFE);
        wr(16'h0203, 16'h0007);
        rd(16'h0202, "R2 addr hi", 16'h3FFE);
        rd(16'h0203, "R2 addr lo low bits", 16'h0004);
        // R3 data halves
        wr(16'h0204, 16'hDEAD);
        wr(16'h0205, 16'hBEEF);
        rd(16'h0204, "R3 data hi", 16'hDEAD);
        rd(16'h0205, "R3 data lo", 16'hBEEF);
        // R5 partial command
        wr(16'h0200, 16'h8000);
        wr(16'h0200, 16'h4000);
        rd(16'h0203, "R5 no advance", 16'h0004);
        // R8 clear, then R4/R7 commit
        wr(16'h0200, 16'h1000);
        rd(16'h0201, "R8 cleared", 16'h0000);
        wr(16'h0200, 16'hC000);
        repeat (WR_LAT) @(negedge clk);
        rd(16'h0201, "R7 crc one word", crc_word(16'h0000, 32'hDEADBEEF));
        rd(16'h0203, "R6 advanced", 16'h0008);
        // second word, chained CRC
        wr(16'h0205, 16'h0001);
        wr(16'h0200, 16'hC000);
        repeat (WR_LAT) @(negedge clk);
        rd(16'h0201, "R7 crc chained",
           crc_word(crc_word(16'h0000, 32'hDEADBEEF), 32'hDEAD0001));
        rd(16'h0203, "R6 advanced twice", 16'h000C);
        // R9 back-to-back commands: second one dropped
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = 16'h0200; reg_wdata = 16'hC000;
        @(negedge clk);
        reg_wdata = 16'hC000;
        @(negedge clk);
        reg_wr = 1'b0;
        repeat (WR_LAT) @(negedge clk);
        rd(16'h0203, "R9 dropped addr", 16'h0010);
        rd(16'h0201, "R9 dropped crc",
           crc_word(crc_word(crc_word(16'h0000, 32'hDEADBEEF), 32'hDEAD0001), 32'hDEAD0001));
        // R8 clear combined with commit
        wr(16'h0200, 16'hD000);
        repeat (WR_LAT) @(negedge clk);
        rd(16'h0201, "R8 clear plus commit", crc_word(16'h0000, 32'hDEAD0001));
        // R6 reload and R10 ignored / unmapped
        wr(16'h0202, 16'h0000);
        wr(16'h0203, 16'h0100);
        rd(16'h0203, "R6 reload", 16'h0100);
        wr(16'h0201, 16'h1234);
        rd(16'h0201, "R10 crc write ignored", crc_word(16'h0000, 32'hDEAD0001));
        rd(16'h0300, "R10 unmapped", 16'h0000);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule